// File: doc/BRIEF.md
# Block-wise Solid-Background Memory Tester

This block is a self-test sequencer for a word-organised static RAM. While its test-enable input is high, it takes over the memory's address, write-data, write-enable and read-data ports. It then runs four passes over the whole array. First it writes every word to all ones, then reads each word back and compares it against ones. Next it writes every word to all zeros, then reads each word back and compares it against zeros. The first read pass finds cells stuck at 0 and the second finds cells stuck at 1.

Each word is compared as a row of 4-bit blocks rather than bit by bit or as a whole word. Every block that differs from the expected background produces a one-cycle fault report on the output. The report carries the word's address and the index of the failing block, so a downstream repair allocator can assign a spare block to exactly that column. When the final compare is finished, a done flag rises. A sticky fail flag shows whether any block mismatched during the run.

Top module: `blk_mem_tester`

## Requirements
- R1: After reset, and while test_en is low in the idle state, mem_we, flt_valid, done and fail are all 0.
- R2: A rising run starts when test_en is high in the idle state. The block then writes every address from 0 upward, one word per cycle, with mem_wdata all ones. Addresses ascend in every pass.
- R3: In the ones read pass, block b is bits [4b+3:4b] of the read word. Each block that is not 4'b1111 yields one report with flt_row set to the word address and flt_blk set to b.
- R4: After the ones read pass, the block writes all words with all zeros and then compares each block against 4'b0000, reporting stuck-at-1 blocks in the same way as R3.
- R5: When one word has several failing blocks, they are reported on consecutive cycles in ascending block index. The next address is issued only after the last report for that word.
- R6: Read data is compared in the cycle after its address is driven, which is one cycle of read latency.
- R7: done rises after the final compare of the zeros pass. It is visible 6N+K+1 clock edges after the start edge, where N is the number of words and K is the total number of reports. It stays high with no writes or reports while test_en remains high.
- R8: fail is set in the cycle of the first report. It stays set until the next start, which clears it. For fault-free memory it remains 0 through done.
- R9: Dropping test_en at any point returns the block to idle on the next edge. From the following cycle, mem_we and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test mode; high starts and holds a run, low aborts |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data (solid background) |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| flt_valid | output | 1 | A fault report is present this cycle |
| flt_row | output | ADDR_W | Word address of the failing block |
| flt_blk | output | IDX_W | Index of the failing 4-bit block |
| done | output | 1 | All four passes finished |
| fail | output | 1 | Sticky: at least one block mismatched |

## Verification
The bench injects stuck bits in the first and last words, in both end blocks of a word, in every block of one word at once, and in a word carrying only a stuck-at-1 fault. A tester that compared whole words would report one entry where several are expected. One that compared at the wrong latency would report a neighbouring row. Completion time is checked against the exact cycle count, so a serializer that skipped or repeated a block, or an address counter that missed the last word, shifts done and is caught. The abort and restart paths are exercised to show that fail clears only on a new start and that writes stop at once when test mode drops.

// File: rtl/blk_tester_pkg.sv
package blk_tester_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR     = 3'd1,
    ST_RD_ADR = 3'd2,
    ST_RD_CMP = 3'd3,
    ST_REPORT = 3'd4,
    ST_FINISH = 3'd5
  } tst_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/blk_addr_seq.sv
module blk_addr_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_top
);

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (inc) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr   = addr_q;
  assign at_top = &addr_q;

  // R2: addresses step upward by exactly one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !at_top) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/blk_cmp_mask.sv
module blk_cmp_mask #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 4,
  localparam int NBLK  = DATA_W / BLK_W
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic              bg,
  output logic [NBLK-1:0]   miss
);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign miss[b] = (rdata[b*BLK_W +: BLK_W] != {BLK_W{bg}});
  end

endmodule

// File: rtl/blk_fault_ser.sv
module blk_fault_ser #(
  parameter int NBLK  = 8,
  localparam int IDX_W = blk_tester_pkg::idx_bits(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBLK-1:0]  mask_in,
  input  logic             pop,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  logic [NBLK-1:0] mask_q, mask_d, pick;

  always_comb begin
    idx = '0;
    for (int b = NBLK - 1; b >= 0; b--) begin
      if (mask_q[b]) idx = IDX_W'(b);
    end
  end

  always_comb begin
    pick = '0;
    pick[idx] = mask_q[idx];
  end

  assign last = ((mask_q & ~pick) == '0);

  always_comb begin
    mask_d = mask_q;
    if (load)     mask_d = mask_in;
    else if (pop) mask_d = mask_q & ~pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R5: each report names a block that is still pending
  a_r5_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> mask_q[idx]);

  // R5: each report retires exactly one pending block
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

endmodule

// File: rtl/blk_mem_tester.sv
module blk_mem_tester #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 4,
  localparam int NBLK  = DATA_W / BLK_W,
  localparam int IDX_W = blk_tester_pkg::idx_bits(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_row,
  output logic [IDX_W-1:0]  flt_blk,
  output logic              done,
  output logic              fail
);

  import blk_tester_pkg::*;

  tst_state_e state_q, state_d;
  logic bg_q, bg_d, fail_q, fail_d;
  logic [ADDR_W-1:0] addr;
  logic at_top;
  logic [NBLK-1:0] miss;
  logic ser_last;
  logic start, any_miss, rd_adv, adv, addr_clr, addr_inc;

  assign start    = (state_q == ST_IDLE) && test_en;
  assign any_miss = |miss;
  assign rd_adv   = ((state_q == ST_RD_CMP) && !any_miss) ||
                    ((state_q == ST_REPORT) && ser_last);
  assign adv      = (state_q == ST_WR) || rd_adv;
  assign addr_clr = start || !test_en || (adv && at_top);
  assign addr_inc = adv && !at_top;

  blk_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .addr(addr), .at_top(at_top)
  );

  blk_cmp_mask #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_cmp (
    .rdata(mem_rdata), .bg(bg_q), .miss(miss)
  );

  blk_fault_ser #(.NBLK(NBLK)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .load(state_q == ST_RD_CMP), .mask_in(miss),
    .pop(state_q == ST_REPORT), .idx(flt_blk), .last(ser_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (test_en) state_d = ST_WR;
      ST_WR:     if (at_top) state_d = ST_RD_ADR;
      ST_RD_ADR: state_d = ST_RD_CMP;
      ST_RD_CMP: begin
        if (any_miss)    state_d = ST_REPORT;
        else if (at_top) state_d = bg_q ? ST_WR : ST_FINISH;
        else             state_d = ST_RD_ADR;
      end
      ST_REPORT: begin
        if (ser_last) begin
          if (at_top) state_d = bg_q ? ST_WR : ST_FINISH;
          else        state_d = ST_RD_ADR;
        end
      end
      ST_FINISH: state_d = ST_FINISH;
      default:   state_d = ST_IDLE;
    endcase
    if (!test_en) state_d = ST_IDLE;
  end

  always_comb begin
    bg_d = bg_q;
    if (start)                        bg_d = 1'b1;
    else if (rd_adv && at_top && bg_q) bg_d = 1'b0;
  end

  always_comb begin
    fail_d = fail_q;
    if (start)                                   fail_d = 1'b0;
    else if ((state_q == ST_RD_CMP) && any_miss) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bg_q    <= 1'b1;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bg_q    <= bg_d;
      fail_q  <= fail_d;
    end
  end

  assign mem_addr  = addr;
  assign mem_we    = (state_q == ST_WR);
  assign mem_wdata = {DATA_W{bg_q}};
  assign flt_valid = (state_q == ST_REPORT);
  assign flt_row   = addr;
  assign done      = (state_q == ST_FINISH);
  assign fail      = fail_q;

  // R9: dropping test mode stops writes and clears done on the next cycle
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (!mem_we && !done));

  // R7: once finished, no memory writes and no reports
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !flt_valid));

  // R8: fail holds until a new run starts
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  // R8: a report is never shown without fail set
  a_r8_report_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> fail);

endmodule

// File: tb/tb_blk_mem_tester.sv
module tb_blk_mem_tester;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam int NB = DW / 4;
  localparam int IW = 2;
  localparam int NVEC = 5;

  // {stuck0 addr, stuck0 mask, stuck1 addr, stuck1 mask}
  localparam logic [39:0] VECS [NVEC] = '{
    {4'd0,  16'h0000, 4'd0,  16'h0000},
    {4'd3,  16'h0010, 4'd0,  16'h0000},
    {4'd0,  16'hF00F, 4'd15, 16'h8000},
    {4'd7,  16'hFFFF, 4'd2,  16'h0100},
    {4'd15, 16'h0001, 4'd0,  16'h00F0}
  };

  logic clk, rst_n, test_en;
  logic [AW-1:0] mem_addr, flt_row;
  logic mem_we, flt_valid, done, fail;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [IW-1:0] flt_blk;

  blk_mem_tester #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .flt_valid(flt_valid), .flt_row(flt_row),
    .flt_blk(flt_blk), .done(done), .fail(fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model with injectable stuck bits, one cycle read latency
  logic [DW-1:0] mem [NW];
  logic [AW-1:0] s0_a, s1_a;
  logic [DW-1:0] s0_m, s1_m;

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (a == s1_a) r = r | s1_m;
    if (a == s0_a) r = r & ~s0_m;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= faulty(mem_addr, mem[mem_addr]);
  end

  int tests, fails;
  int got_n;
  int got_row [64];
  int got_blk [64];
  int exp_n;
  int exp_row [64];
  int exp_blk [64];
  int we_seen;

  always @(negedge clk) begin
    if (flt_valid && got_n < 64) begin
      got_row[got_n] = int'(flt_row);
      got_blk[got_n] = int'(flt_blk);
      got_n++;
    end
    if (mem_we) we_seen++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_expected();
    exp_n = 0;
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < NB; b++)
        if (a == int'(s0_a) && (s0_m[b*4 +: 4] != 4'h0)) begin
          exp_row[exp_n] = a; exp_blk[exp_n] = b; exp_n++;
        end
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < NB; b++)
        if (a == int'(s1_a) && (s1_m[b*4 +: 4] != 4'h0)) begin
          exp_row[exp_n] = a; exp_blk[exp_n] = b; exp_n++;
        end
  endtask

  // start a run and return the number of edges until done
  task automatic run(output int edges);
    got_n = 0;
    edges = 0;
    test_en = 1'b1;
    while (edges < 2000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done) break;
    end
  endtask

  initial begin
    tests = 0; fails = 0; got_n = 0; we_seen = 0;
    s0_a = '0; s1_a = '0; s0_m = '0; s1_m = '0;
    test_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "flt_valid", int'(flt_valid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "fail", int'(fail), 0);
    rst_n = 1'b1;
    we_seen = 0;
    repeat (5) @(negedge clk);
    chk("R1", "writes while idle", we_seen, 0);
    chk("R1", "done while idle", int'(done), 0);

    // vector table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      int edges;
      s0_a = VECS[v][39:36]; s0_m = VECS[v][35:20];
      s1_a = VECS[v][19:16]; s1_m = VECS[v][15:0];
      build_expected();
      we_seen = 0;
      run(edges);
      chk("R7", $sformatf("vec%0d done", v), int'(done), 1);
      chk("R7", $sformatf("vec%0d edges to done", v), edges, 6*NW + exp_n + 1);
      chk("R2", $sformatf("vec%0d write count", v), we_seen, 2*NW);
      chk("R3", $sformatf("vec%0d report count", v), got_n, exp_n);
      for (int k = 0; k < exp_n && k < got_n; k++) begin
        chk("R5", $sformatf("vec%0d rpt%0d row", v, k), got_row[k], exp_row[k]);
        chk("R5", $sformatf("vec%0d rpt%0d blk", v, k), got_blk[k], exp_blk[k]);
      end
      chk("R8", $sformatf("vec%0d fail", v), int'(fail), (exp_n > 0) ? 1 : 0);
      test_en = 1'b0;
      @(negedge clk);
      chk("R9", "done after drop", int'(done), 0);
      if (exp_n > 0) chk("R8", "fail held in idle", int'(fail), 1);
      @(negedge clk);
    end

    // R7: done holds while test_en stays high
    begin
      int edges;
      s0_a = 4'd5; s0_m = 16'h0F00; s1_a = 4'd0; s1_m = '0;
      run(edges);
      chk("R8", "fail after fault run", int'(fail), 1);
      we_seen = 0; got_n = 0;
      repeat (6) @(negedge clk);
      chk("R7", "done holds", int'(done), 1);
      chk("R7", "no writes after done", we_seen, 0);
      chk("R7", "no reports after done", got_n, 0);
      test_en = 1'b0;
      repeat (2) @(negedge clk);
      // R8: new start clears fail
      s0_m = '0;
      test_en = 1'b1;
      @(negedge clk);
      chk("R8", "fail cleared by start", int'(fail), 0);
      chk("R2", "first write enabled", int'(mem_we), 1);
      chk("R2", "first write addr", int'(mem_addr), 0);
      chk("R2", "ones background", int'(mem_wdata), 16'hFFFF);
      @(negedge clk);
      chk("R2", "second write addr", int'(mem_addr), 1);
    end

    // R9: abort mid-run
    repeat (8) @(negedge clk);
    test_en = 1'b0;
    @(negedge clk);
    we_seen = 0;
    chk("R9", "we after abort", int'(mem_we), 0);
    chk("R9", "done after abort", int'(done), 0);
    repeat (5) @(negedge clk);
    chk("R9", "writes while aborted", we_seen, 0);

    // R4 R6: stuck-at-1 only, in first word, block 0
    begin
      int edges;
      s0_a = 4'd0; s0_m = '0; s1_a = 4'd0; s1_m = 16'h0002;
      run(edges);
      chk("R4", "s1 report count", got_n, 1);
      chk("R6", "s1 row", got_row[0], 0);
      chk("R4", "s1 blk", got_blk[0], 0);
      chk("R7", "s1 edges", edges, 6*NW + 2);
      test_en = 1'b0;
      @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule